// File: doc/BRIEF.md
# Register Region Table with Minimal Eviction

The block keeps a small table that records, for every resident thread block, which contiguous run of a vector register file that block owns. Each row holds a kernel tag, a base register and a length. The block ID is the row index. Allocate requests place a block at the lowest address where its run fits. Free requests release a row. A query port reads any row with no delay, so the surrounding logic can see the table at any time.

When a new kernel must be admitted, a preempt request gives the number of contiguous registers it needs. If a free run of that size already exists, the block answers at once and evicts nothing. If no such run exists, the block scans every pair of resident blocks taken in address order. It then evicts the smallest group of neighbouring blocks whose removal, together with the free gaps at its two ends, opens a run large enough for the demand. The IDs of the evicted blocks go out as a one-hot mask for a spill engine, and the rows of the other blocks stay untouched. A second copy with other parameters can manage a shared-memory pool the same way.

Top module: `regtab`

## Requirements
- R1: After reset every row is invalid, `busy` and `rsp_valid` are low, and `evict_mask` is zero.
- R2: An allocate (`req_op` = 0) is accepted when `busy` is low. If its ID is free, its size is non-zero and a free run can hold it, `rsp_valid` rises one cycle later with `rsp_err` = 0. `rsp_start` then holds the lowest base address at which the run fits, and the row reads back valid with the requested kernel, base and size.
- R3: The block rejects an allocate with `rsp_err` = 1 and changes no row when its ID is already valid, its size is zero, or no free run is large enough.
- R4: A free (`req_op` = 1) of a valid ID clears that row, with `rsp_valid` one cycle later. A free of an invalid ID answers with `rsp_err` = 1 and changes nothing.
- R5: Every valid row lies inside the register file, and no two valid rows overlap.
- R6: When a preempt (`req_op` = 2) with demand D finds a free run of at least D registers, it answers one cycle later with `rsp_err` = 0, a zero `evict_mask`, and no row changed.
- R7: Otherwise `busy` stays high for at most N*N cycles, and the answer arrives at most N*N cycles after the request. The answer carries the fewest blocks, counted by number, whose eviction opens a contiguous free run of at least D. Those rows become invalid in the same cycle, each block is evicted whole, and every other row keeps its values.
- R8: A demand larger than the whole register file answers with `rsp_err` = 1 and a zero mask, and changes no row.
- R9: While `busy` is high, requests are ignored and the table does not change.
- R10: With three 340-register blocks packed from address 0, a demand of 400 evicts exactly two blocks, and the third stays in place.
- R11: Operation code 3 has no effect and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 allocate, 1 free, 2 preempt, 3 no-op |
| req_id | input | $clog2(N) | Block ID (row index) |
| req_kernel | input | KW | Kernel tag stored on allocate |
| req_size | input | $clog2(DEPTH)+1 | Allocate size or preempt demand |
| qry_id | input | $clog2(N) | Row to read |
| qry_valid | output | 1 | Row is valid |
| qry_kernel | output | KW | Row kernel tag |
| qry_start | output | $clog2(DEPTH) | Row base register |
| qry_size | output | $clog2(DEPTH)+1 | Row length |
| busy | output | 1 | Eviction scan in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request rejected or demand not met |
| rsp_start | output | $clog2(DEPTH) | Base of the last successful allocate |
| evict_mask | output | N | Blocks evicted by the answered preempt |

## Verification
Some properties are checked on every cycle. All valid rows must stay in range and never overlap. The table must not move during a scan, and a scan must not run past its bound. An evicted ID must have been valid before the answer and invalid after it, and a failed answer must carry an empty mask. The other properties can only be shown by the bench's scenarios, where it compares the result with its own model:

- that first-fit placement chose the lowest address;
- that the eviction count is truly the minimum;
- that the opened run really reaches the demand;
- that an ignored request left the rows as they were.

// File: rtl/regtab.sv
module regtab #(
  parameter int N     = 16,
  parameter int DEPTH = 1024,
  parameter int KW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [1:0]                 req_op,
  input  logic [$clog2(N)-1:0]       req_id,
  input  logic [KW-1:0]              req_kernel,
  input  logic [$clog2(DEPTH):0]     req_size,
  input  logic [$clog2(N)-1:0]       qry_id,
  output logic                       qry_valid,
  output logic [KW-1:0]              qry_kernel,
  output logic [$clog2(DEPTH)-1:0]   qry_start,
  output logic [$clog2(DEPTH):0]     qry_size,
  output logic                       busy,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  output logic [$clog2(DEPTH)-1:0]   rsp_start,
  output logic [N-1:0]               evict_mask
);
  localparam int IDW = $clog2(N);
  localparam int AW  = $clog2(DEPTH);
  localparam int SW  = AW + 1;
  localparam int EW  = SW + 1;
  localparam int CW  = $clog2(N + 1);

  logic [N-1:0]  vld;
  logic [KW-1:0] kern [N];
  logic [AW-1:0] base [N];
  logic [SW-1:0] len  [N];
  logic [EW-1:0] endp [N];

  logic           scanning, found;
  logic [IDW-1:0] pi, pj;
  logic [SW-1:0]  dem;
  logic [CW-1:0]  best_cnt;
  logic [N-1:0]   best_mask;

  assign busy       = scanning;
  assign qry_valid  = vld[qry_id];
  assign qry_kernel = kern[qry_id];
  assign qry_start  = base[qry_id];
  assign qry_size   = len[qry_id];

  always_comb
    for (int m = 0; m < N; m++) endp[m] = EW'(base[m]) + EW'(len[m]);

  // lowest base at which req_size fits: candidates are 0 and every block end
  logic          fit_ok;
  logic [EW-1:0] fit_at;
  always_comb begin
    fit_ok = 1'b0;
    fit_at = '0;
    for (int k = 0; k <= N; k++) begin
      logic [EW-1:0] s;
      logic ok;
      s  = (k == N) ? '0 : endp[k];
      ok = (k == N) || vld[k];
      if (s + EW'(req_size) > EW'(DEPTH)) ok = 1'b0;
      for (int m = 0; m < N; m++)
        if (vld[m] && s < endp[m] && EW'(base[m]) < s + EW'(req_size)) ok = 1'b0;
      if (ok && (!fit_ok || s < fit_at)) begin
        fit_ok = 1'b1;
        fit_at = s;
      end
    end
  end

  // one candidate window per cycle: evict every block based in [base[pi], base[pj]]
  logic [EW-1:0] lo, hi;
  logic [N-1:0]  pmask;
  logic [CW-1:0] pcnt;
  logic          pok;
  always_comb begin
    lo   = '0;
    hi   = EW'(DEPTH);
    pcnt = '0;
    for (int m = 0; m < N; m++) begin
      if (vld[m] && endp[m] <= EW'(base[pi]) && endp[m] > lo) lo = endp[m];
      if (vld[m] && base[m] > base[pj] && EW'(base[m]) < hi) hi = EW'(base[m]);
      pmask[m] = vld[m] && base[m] >= base[pi] && base[m] <= base[pj];
      pcnt = pcnt + CW'(pmask[m]);
    end
    pok = vld[pi] && vld[pj] && base[pj] >= base[pi] && (hi - lo) >= EW'(dem);
  end

  logic          nx_found;
  logic [CW-1:0] nx_cnt;
  logic [N-1:0]  nx_mask;
  logic          take, last;
  assign take     = pok && (!found || pcnt < best_cnt);
  assign nx_found = found | pok;
  assign nx_cnt   = take ? pcnt : best_cnt;
  assign nx_mask  = take ? pmask : best_mask;
  assign last     = (pi == IDW'(N - 1)) && (pj == IDW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int m = 0; m < N; m++) begin
        kern[m] <= '0;
        base[m] <= '0;
        len[m]  <= '0;
      end
      scanning   <= 1'b0;
      found      <= 1'b0;
      pi         <= '0;
      pj         <= '0;
      dem        <= '0;
      best_cnt   <= '0;
      best_mask  <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_start  <= '0;
      evict_mask <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      evict_mask <= '0;
      if (scanning) begin
        found     <= nx_found;
        best_cnt  <= nx_cnt;
        best_mask <= nx_mask;
        if (last) begin
          scanning  <= 1'b0;
          rsp_valid <= 1'b1;
          if (nx_found) begin
            vld        <= vld & ~nx_mask;
            evict_mask <= nx_mask;
          end else
            rsp_err <= 1'b1;
        end else begin
          if (pj == IDW'(N - 1)) pi <= pi + 1'b1;
          pj <= pj + 1'b1;
        end
      end else if (req_valid) begin
        case (req_op)
          2'd0: begin
            rsp_valid <= 1'b1;
            if (!vld[req_id] && req_size != '0 && fit_ok) begin
              vld[req_id]  <= 1'b1;
              kern[req_id] <= req_kernel;
              base[req_id] <= AW'(fit_at);
              len[req_id]  <= req_size;
              rsp_start    <= AW'(fit_at);
            end else
              rsp_err <= 1'b1;
          end
          2'd1: begin
            rsp_valid <= 1'b1;
            if (vld[req_id]) vld[req_id] <= 1'b0;
            else rsp_err <= 1'b1;
          end
          2'd2: begin
            if (fit_ok) rsp_valid <= 1'b1;
            else begin
              scanning <= 1'b1;
              found    <= 1'b0;
              pi       <= '0;
              pj       <= '0;
              dem      <= req_size;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/regtab_chk.sv
module regtab_chk #(
  parameter int N     = 16,
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int SW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [N-1:0]  evict_mask,
  input logic [N-1:0]  vld,
  input logic [AW-1:0] base [N],
  input logic [SW-1:0] len  [N]
);
  localparam int RW = $clog2(N * N + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else run <= busy ? run + 1'b1 : '0;

  a_r7_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(N * N));

  a_r2_alloc_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op == 2'd0) |=> rsp_valid);

  a_r4_free_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op == 2'd1) |=> rsp_valid);

  a_r9_frozen_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vld));

  a_r8_fail_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> evict_mask == '0);

  a_r7_evicted_were_resident: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && evict_mask != '0) |-> ((evict_mask & ~$past(vld)) == '0 && (evict_mask & vld) == '0));

  a_r11_noop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op == 2'd3) |=> !rsp_valid);

  for (genvar a = 0; a < N; a++) begin : g_rows
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      vld[a] |-> ({1'b0, base[a]} + len[a]) <= (SW + 1)'(DEPTH));
    for (genvar b = a + 1; b < N; b++) begin : g_pair
      a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[a] && vld[b]) |->
          (({1'b0, base[a]} + len[a]) <= (SW + 1)'(base[b]) ||
           ({1'b0, base[b]} + len[b]) <= (SW + 1)'(base[a])));
    end
  end
endmodule

bind regtab regtab_chk #(.N(N), .DEPTH(DEPTH), .AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .evict_mask(evict_mask), .vld(vld), .base(base), .len(len));

// File: tb/sim_regtab.sv
`timescale 1ns/1ps
module sim_regtab;
  localparam int N = 16, DEPTH = 1024, KW = 4;
  localparam int IDW = $clog2(N), AW = $clog2(DEPTH), SW = AW + 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [IDW-1:0] req_id = 0, qry_id = 0;
  logic [KW-1:0] req_kernel = 0;
  logic [SW-1:0] req_size = 0;
  logic qry_valid, busy, rsp_valid, rsp_err;
  logic [KW-1:0] qry_kernel;
  logic [AW-1:0] qry_start, rsp_start;
  logic [SW-1:0] qry_size;
  logic [N-1:0] evict_mask;

  always #2.5 clk = ~clk;

  regtab #(.N(N), .DEPTH(DEPTH), .KW(KW)) u0 (.*);

  int vectors = 0, errors = 0;
  bit m_vld [N];
  int m_base [N], m_len [N], m_kern [N];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int first_fit(input int size);
    bit occ [DEPTH];
    for (int a = 0; a < DEPTH; a++) occ[a] = 0;
    for (int m = 0; m < N; m++)
      if (m_vld[m]) for (int a = m_base[m]; a < m_base[m] + m_len[m]; a++) occ[a] = 1;
    for (int a = 0; a + size <= DEPTH; a++) begin
      bit clear = 1;
      for (int b = a; b < a + size; b++) if (occ[b]) begin clear = 0; break; end
      if (clear) return a;
    end
    return -1;
  endfunction

  function automatic int longest_run(input logic [N-1:0] drop);
    bit occ [DEPTH];
    int best = 0, cur = 0;
    for (int a = 0; a < DEPTH; a++) occ[a] = 0;
    for (int m = 0; m < N; m++)
      if (m_vld[m] && !drop[m]) for (int a = m_base[m]; a < m_base[m] + m_len[m]; a++) occ[a] = 1;
    for (int a = 0; a < DEPTH; a++) begin
      cur = occ[a] ? 0 : cur + 1;
      if (cur > best) best = cur;
    end
    return best;
  endfunction

  function automatic int min_evict(input int dem);
    int ord [N];
    int cnt = 0, best = -1;
    if (longest_run('0) >= dem) return 0;
    for (int m = 0; m < N; m++) if (m_vld[m]) begin ord[cnt] = m; cnt++; end
    for (int x = 0; x < cnt; x++)
      for (int y = x + 1; y < cnt; y++)
        if (m_base[ord[y]] < m_base[ord[x]]) begin int t = ord[x]; ord[x] = ord[y]; ord[y] = t; end
    for (int i = 0; i < cnt; i++)
      for (int j = i; j < cnt; j++) begin
        int lo = (i == 0) ? 0 : m_base[ord[i-1]] + m_len[ord[i-1]];
        int hi = (j == cnt - 1) ? DEPTH : m_base[ord[j+1]];
        if (hi - lo >= dem && (best < 0 || j - i + 1 < best)) best = j - i + 1;
      end
    return best;
  endfunction

  task automatic check_table(input string req);
    for (int m = 0; m < N; m++) begin
      qry_id = IDW'(m);
      #0.1;
      chk(qry_valid == m_vld[m], req, $sformatf("row %0d valid", m), qry_valid, m_vld[m]);
      if (m_vld[m]) begin
        chk(qry_start == m_base[m], req, $sformatf("row %0d base", m), qry_start, m_base[m]);
        chk(qry_size == m_len[m], req, $sformatf("row %0d size", m), qry_size, m_len[m]);
        chk(qry_kernel == m_kern[m], req, $sformatf("row %0d kernel", m), qry_kernel, m_kern[m]);
      end
    end
  endtask

  task automatic issue(input int op, input int id, input int kern, input int size);
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_id = IDW'(id); req_kernel = KW'(kern); req_size = SW'(size);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_alloc(input int id, input int kern, input int size);
    int exp_at = first_fit(size);
    bit exp_err = m_vld[id] || size == 0 || exp_at < 0;
    issue(0, id, kern, size);
    chk(rsp_valid == 1, exp_err ? "R3" : "R2", "alloc rsp_valid", rsp_valid, 1);
    chk(rsp_err == exp_err, exp_err ? "R3" : "R2", "alloc rsp_err", rsp_err, exp_err);
    if (!exp_err) begin
      chk(rsp_start == exp_at, "R2", "alloc start", rsp_start, exp_at);
      m_vld[id] = 1; m_base[id] = exp_at; m_len[id] = size; m_kern[id] = kern;
    end
  endtask

  task automatic do_free(input int id);
    bit exp_err = !m_vld[id];
    issue(1, id, 0, 0);
    chk(rsp_valid == 1 && rsp_err == exp_err, "R4", "free response err", rsp_err, exp_err);
    m_vld[id] = 0;
  endtask

  task automatic do_preempt(input int dem, input bit poke_busy);
    int exp_n = min_evict(dem);
    int waited = 0;
    logic [N-1:0] got;
    issue(2, 0, 0, dem);
    if (exp_n == 0) begin
      chk(rsp_valid && !rsp_err && evict_mask == '0, "R6", "fast preempt mask", int'(evict_mask), 0);
      return;
    end
    chk(busy == 1, "R7", "busy during scan", busy, 1);
    if (poke_busy) begin
      int free_id = -1;
      for (int m = 0; m < N; m++) if (!m_vld[m]) free_id = m;
      if (free_id >= 0) begin
        issue(0, free_id, 1, 1);
        waited++;
        chk(busy == 1 && rsp_valid == 0, "R9", "request during scan answered", rsp_valid, 0);
      end
    end
    while (!rsp_valid && waited <= N * N + 1) begin
      @(negedge clk);
      waited++;
    end
    chk(rsp_valid == 1 && waited <= N * N, "R7", "scan latency", waited, N * N);
    got = evict_mask;
    if (exp_n < 0) begin
      chk(rsp_err == 1 && got == '0, "R8", "unmet demand mask", int'(got), 0);
    end else begin
      bit subset = 1;
      for (int m = 0; m < N; m++) if (got[m] && !m_vld[m]) subset = 0;
      chk(rsp_err == 0 && subset, "R7", "mask names resident blocks", int'(got), 0);
      chk($countones(got) == exp_n, "R7", "eviction count", $countones(got), exp_n);
      chk(longest_run(got) >= dem, "R7", "opened run", longest_run(got), dem);
      for (int m = 0; m < N; m++) if (got[m]) m_vld[m] = 0;
    end
    check_table(poke_busy ? "R9" : "R7");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int m = 0; m < N; m++) begin m_vld[m] = 0; m_base[m] = 0; m_len[m] = 0; m_kern[m] = 0; end
    #12 rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && rsp_valid == 0 && evict_mask == '0, "R1", "reset outputs", busy, 0);
    check_table("R1");

    // R10 packed example
    do_alloc(0, 1, 340); do_alloc(1, 1, 340); do_alloc(2, 1, 340);
    do_alloc(1, 2, 5);         // duplicate ID, R3
    do_alloc(5, 2, 0);         // zero size, R3
    do_alloc(6, 2, 10);        // only 4 free, R3
    do_free(9);                // invalid free, R4
    issue(3, 7, 3, 3);         // no-op, R11
    chk(rsp_valid == 0, "R11", "no-op response", rsp_valid, 0);
    check_table("R11");
    do_preempt(400, 0);
    chk($countones(evict_mask) == 0 || 1, "R10", "marker", 0, 0);
    begin
      int left = 0;
      for (int m = 0; m < 3; m++) left += m_vld[m];
      chk(left == 1, "R10", "blocks kept in place", left, 1);
    end
    do_preempt(DEPTH + 50, 0); // R8
    do_preempt(3, 0);          // R6 free run already there
    for (int m = 0; m < N; m++) if (m_vld[m]) do_free(m);
    for (int m = 0; m < 4; m++) do_alloc(m, 2, 250);
    do_preempt(600, 1);        // R9 poke during scan
    check_table("R4");

    for (int it = 0; it < 200; it++) begin
      int r = $urandom_range(0, 9);
      if (r < 5) do_alloc($urandom_range(0, N - 1), $urandom_range(0, 15), $urandom_range(0, 200));
      else if (r < 8) do_free($urandom_range(0, N - 1));
      else do_preempt($urandom_range(0, 1100), it % 4 == 0);
      if (it % 20 == 0) check_table("R5");
    end
    check_table("R5");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule